// File: doc/BRIEF.md
# Buffered Serial Transmitter with Break Generation

This block turns parallel characters from a host into an asynchronous serial bit stream. A single-entry holding register takes each host write and passes it to a frame shifter, so the host can queue the next character while the current one is still on the line. Each character can be sent as 8 data bits or as 9 data bits. In 9-bit mode the extra bit comes from a side input, which is captured together with the data on the write.

Bit timing comes entirely from an external one-cycle bit tick. Every tick moves the line by one bit period. The block can also send a break character: the line is held low for thirteen bit periods and then returns high for one stop period. Two flags report progress. One shows that the holding register is empty, and it drives an interrupt output when interrupts are enabled. The other shows that the shifter is idle.

Top module: `uart_tx_top`

## Requirements
- R1: After reset, `txd_o` is 1, `buf_empty_o` is 1, `shift_empty_o` is 1 and `irq_o` equals `irq_en_i`.
- R2: A data frame is sent least significant bit first. It consists of one low start bit, the data bits and one high stop bit. Each bit lasts from one tick to the next, and the start bit appears on the tick that loads the shifter.
- R3: In 9-bit mode (`nine_bit_i`=1 at the write), the frame has a ninth data bit equal to `bit9_i` as sampled at the write. That bit sits between data bit 7 and the stop bit. In 8-bit mode `bit9_i` has no effect.
- R4: A full holding register moves into the shifter on the first tick that arrives while the shifter is idle. `buf_empty_o` rises and `shift_empty_o` falls in that same cycle. The shifter becomes idle again on the tick that ends the stop bit.
- R5: A write while the holding register is full is ignored. The held character stays unchanged and is the one that is sent.
- R6: `irq_o` is 1 exactly when `irq_en_i` is 1 and the holding register is empty.
- R7: A break request is sent as one frame made of 13 low bit periods followed by one high stop period.
- R8: A pending break takes priority over a buffered character at load time. A character written before or during the break is sent after it.
- R9: While `tx_en_i` is 0, the shifter is idle and `txd_o` is 1. A frame in progress is cut off, and break requests are dropped. The holding register keeps its character.
- R10: `txd_o` is 1 whenever the shifter is idle, and it does not change in a cycle with no tick while `tx_en_i` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable |
| tick_i | input | 1 | One-cycle bit-period strobe |
| wr_valid_i | input | 1 | Host write strobe |
| wr_data_i | input | DATA_W | Host write character |
| nine_bit_i | input | 1 | Frame has a ninth data bit (sampled at write) |
| bit9_i | input | 1 | Ninth data bit value (sampled at write) |
| break_req_i | input | 1 | One-cycle break request |
| irq_en_i | input | 1 | Interrupt enable |
| irq_o | output | 1 | Holding register empty interrupt |
| buf_empty_o | output | 1 | Holding register empty |
| shift_empty_o | output | 1 | Shifter idle |
| txd_o | output | 1 | Serial output, idles high |

## Verification
The assertions assume that `tick_i` is a strobe one clock wide and that `break_req_i` and `wr_valid_i` are single-cycle pulses. They do not assume any spacing between ticks. The bench drives inputs on the falling edge, with at least one tick-free cycle between ticks. It writes data only in cycles with no tick, so every load and shift it checks occurs at a known edge. The bench sweeps every 8-bit value, and a spread of 9-bit values with both settings of the ninth bit.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    LOAD_NONE  = 2'd0,
    LOAD_DATA  = 2'd1,
    LOAD_BREAK = 2'd2
  } load_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              nine_bit_i,
  input  logic              bit9_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o,
  output logic              nine_o,
  output logic              bit9_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              nine_q, bit9_q;
  logic              accept;

  assign accept = wr_valid_i && !full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
      nine_q <= 1'b0;
      bit9_q <= 1'b0;
    end else begin
      if (accept) begin
        full_q <= 1'b1;
        data_q <= wr_data_i;
        nine_q <= nine_bit_i;
        bit9_q <= bit9_i;
      end else if (take_i) begin
        full_q <= 1'b0;
      end
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
  assign nine_o = nine_q;
  assign bit9_o = bit9_q;

  // R5: held character survives writes while full
  a_r5_write_full_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && full_q) |=> ($stable(data_o) && $stable(nine_o) && $stable(bit9_o)));

  // R4: a take always frees the register
  a_r4_take_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> !full_o);

  a_r4_take_only_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> full_q);
endmodule

// File: rtl/tx_load_ctrl.sv
module tx_load_ctrl
  import uart_tx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tx_en_i,
  input  logic  tick_i,
  input  logic  break_req_i,
  input  logic  shift_idle_i,
  input  logic  buf_full_i,
  output load_e load_o,
  output logic  take_o
);
  logic brk_pend_q;
  logic can_load;

  assign can_load = tx_en_i && tick_i && shift_idle_i;

  always_comb begin
    load_o = LOAD_NONE;
    if (can_load) begin
      if (brk_pend_q)      load_o = LOAD_BREAK;
      else if (buf_full_i) load_o = LOAD_DATA;
    end
  end

  assign take_o = (load_o == LOAD_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       brk_pend_q <= 1'b0;
    else if (!tx_en_i) brk_pend_q <= 1'b0;
    else               brk_pend_q <= break_req_i || (brk_pend_q && (load_o != LOAD_BREAK));
  end

  // R8: break wins over buffered data
  a_r8_break_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (can_load && brk_pend_q) |-> !take_o);

  // R9: nothing loads while disabled
  a_r9_no_load_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |-> (load_o == LOAD_NONE));

  a_r4_load_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o != LOAD_NONE) |-> (tick_i && shift_idle_i));
endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned BRK_ZEROS = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              tick_i,
  input  load_e             load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              nine_i,
  input  logic              bit9_i,
  output logic              busy_o,
  output logic              txd_o
);
  localparam int unsigned SR_W  = max2(DATA_W + 3, BRK_ZEROS + 1);
  localparam int unsigned CNT_W = $clog2(SR_W);

  logic [SR_W-1:0]  sr_q, frame;
  logic [CNT_W-1:0] cnt_q, last_q, last_d;
  logic             busy_q;

  // frame image: bit 0 leaves first, unused upper bits stay high
  always_comb begin
    frame  = '1;
    last_d = '0;
    if (load_i == LOAD_BREAK) begin
      frame[BRK_ZEROS-1:0] = '0;
      last_d = CNT_W'(BRK_ZEROS);
    end else begin
      frame[0]        = 1'b0;
      frame[DATA_W:1] = data_i;
      if (nine_i) frame[DATA_W+1] = bit9_i;
      last_d = CNT_W'(DATA_W + 1) + CNT_W'(nine_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sr_q   <= '1;
      cnt_q  <= '0;
      last_q <= '0;
    end else if (!tx_en_i) begin
      busy_q <= 1'b0;
      sr_q   <= '1;
      cnt_q  <= '0;
    end else if (load_i != LOAD_NONE) begin
      busy_q <= 1'b1;
      sr_q   <= frame;
      cnt_q  <= '0;
      last_q <= last_d;
    end else if (busy_q && tick_i) begin
      if (cnt_q == last_q) begin
        busy_q <= 1'b0;
        sr_q   <= '1;
      end else begin
        sr_q  <= {1'b1, sr_q[SR_W-1:1]};
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign txd_o  = busy_q ? sr_q[0] : 1'b1;

  // R10: idle line is high
  a_r10_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> txd_o);

  // R10: no bit change without a tick
  a_r10_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && tx_en_i) |=> $stable(txd_o));

  // R2: a load starts with a low start bit
  a_r2_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && load_i != LOAD_NONE) |=> (busy_o && !txd_o));

  // R9: disable forces idle
  a_r9_disable_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> !busy_o);
endmodule

// File: rtl/uart_tx_top.sv
module uart_tx_top
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned BRK_ZEROS = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              tick_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              nine_bit_i,
  input  logic              bit9_i,
  input  logic              break_req_i,
  input  logic              irq_en_i,
  output logic              irq_o,
  output logic              buf_empty_o,
  output logic              shift_empty_o,
  output logic              txd_o
);
  logic              buf_full, take, busy;
  logic [DATA_W-1:0] hold_data;
  logic              hold_nine, hold_bit9;
  load_e             load;

  tx_hold_buf #(.DATA_W(DATA_W)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .wr_data_i  (wr_data_i),
    .nine_bit_i (nine_bit_i),
    .bit9_i     (bit9_i),
    .take_i     (take),
    .full_o     (buf_full),
    .data_o     (hold_data),
    .nine_o     (hold_nine),
    .bit9_o     (hold_bit9)
  );

  tx_load_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tx_en_i      (tx_en_i),
    .tick_i       (tick_i),
    .break_req_i  (break_req_i),
    .shift_idle_i (!busy),
    .buf_full_i   (buf_full),
    .load_o       (load),
    .take_o       (take)
  );

  tx_frame_shifter #(.DATA_W(DATA_W), .BRK_ZEROS(BRK_ZEROS)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tx_en_i (tx_en_i),
    .tick_i  (tick_i),
    .load_i  (load),
    .data_i  (hold_data),
    .nine_i  (hold_nine),
    .bit9_i  (hold_bit9),
    .busy_o  (busy),
    .txd_o   (txd_o)
  );

  assign buf_empty_o   = !buf_full;
  assign shift_empty_o = !busy;
  assign irq_o         = irq_en_i && buf_empty_o;

  // R4: a data transfer frees the buffer and starts the shifter together
  a_r4_transfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(buf_empty_o) && tx_en_i) |-> $fell(shift_empty_o));

  // R6: interrupt follows enable and empty flag
  a_r6_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_en_i && buf_empty_o));
endmodule

// File: tb/uart_tx_top_tb_top.sv
module uart_tx_top_tb_top;
  localparam int CLK_P = 10;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       tx_en_i = 1'b0, tick_i = 1'b0, wr_valid_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       nine_bit_i = 1'b0, bit9_i = 1'b0, break_req_i = 1'b0, irq_en_i = 1'b0;
  logic       irq_o, buf_empty_o, shift_empty_o, txd_o;

  int errors = 0, checks = 0;

  uart_tx_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tx_en_i(tx_en_i), .tick_i(tick_i),
    .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i), .nine_bit_i(nine_bit_i),
    .bit9_i(bit9_i), .break_req_i(break_req_i), .irq_en_i(irq_en_i),
    .irq_o(irq_o), .buf_empty_o(buf_empty_o), .shift_empty_o(shift_empty_o),
    .txd_o(txd_o)
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one tick pulse; ends at a falling edge after the tick edge
  task automatic tick();
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic write(input logic [7:0] d, input logic nine, input logic b9);
    wr_valid_i = 1'b1; wr_data_i = d; nine_bit_i = nine; bit9_i = b9;
    @(negedge clk_i);
    wr_valid_i = 1'b0; nine_bit_i = 1'b0; bit9_i = 1'b0;
    @(negedge clk_i);
  endtask

  // expected line level for bit k of a data frame
  function automatic logic exp_bit(input int k, input logic [7:0] d, input logic nine, input logic b9);
    if (k == 0) return 1'b0;
    if (k <= 8) return d[k-1];
    if (nine && k == 9) return b9;
    return 1'b1;
  endfunction

  // shifter idle, buffer full: load and follow a whole frame
  task automatic run_frame(input string req, input logic [7:0] d, input logic nine, input logic b9);
    int n;
    logic [15:0] got, exp;
    n = nine ? 11 : 10;
    got = '0; exp = '0;
    for (int k = 0; k < n; k++) begin
      tick();
      got[k] = txd_o;
      exp[k] = exp_bit(k, d, nine, b9);
    end
    chk(req, got, exp);
    tick();
    chk({req, " idle after stop"}, {shift_empty_o, txd_o}, 2'b11);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1 reset", {txd_o, buf_empty_o, shift_empty_o, irq_o}, 4'b1110);
    irq_en_i = 1'b1; #1;
    chk("R1 irq follows enable", irq_o, 1'b1);
    rst_ni = 1'b1; tx_en_i = 1'b1;
    @(negedge clk_i);

    // R2: every 8-bit value
    for (int v = 0; v < 256; v++) begin
      write(v[7:0], 1'b0, v[0]);  // R3: bit9_i ignored in 8-bit mode
      run_frame("R2 8-bit frame", v[7:0], 1'b0, 1'b0);
    end

    // R3: 9-bit frames with both ninth-bit values
    for (int v = 0; v < 256; v += 7) begin
      for (int b = 0; b < 2; b++) begin
        write(v[7:0], 1'b1, b[0]);
        run_frame("R3 9-bit frame", v[7:0], 1'b1, b[0]);
      end
    end

    // R6: interrupt gating
    irq_en_i = 1'b0; #1;
    chk("R6 irq disabled", irq_o, 1'b0);
    irq_en_i = 1'b1;
    write(8'h3C, 1'b0, 1'b0);
    chk("R6 irq low when full", irq_o, 1'b0);

    // R10: no change without a tick
    repeat (5) @(negedge clk_i);
    chk("R10 idle until tick", {txd_o, shift_empty_o, buf_empty_o}, 3'b110);

    // R4: transfer on tick, flags flip together
    tick();
    chk("R4 transfer flags", {buf_empty_o, shift_empty_o, txd_o}, 3'b100);
    chk("R6 irq after transfer", irq_o, 1'b1);
    write(8'hA5, 1'b0, 1'b0);
    write(8'h0F, 1'b0, 1'b0);  // R5: full, ignored
    chk("R5 still full", buf_empty_o, 1'b0);
    begin
      logic [15:0] got, exp;
      got = '0; exp = '0;
      for (int k = 1; k < 10; k++) begin
        tick();
        got[k] = txd_o; exp[k] = exp_bit(k, 8'h3C, 1'b0, 1'b0);
      end
      chk("R2 first frame of pair", got, exp);
    end
    tick();
    chk("R4 idle gap, buffer still full", {shift_empty_o, buf_empty_o}, 2'b10);
    run_frame("R5 held character sent", 8'hA5, 1'b0, 1'b0);
    tick(); tick();
    chk("R5 dropped write never sent", {shift_empty_o, buf_empty_o, txd_o}, 3'b111);

    // R7/R8: break with data queued before and during it
    write(8'h81, 1'b0, 1'b0);
    break_req_i = 1'b1; @(negedge clk_i); break_req_i = 1'b0;
    begin
      logic [15:0] got;
      got = '0;
      for (int k = 0; k < 14; k++) begin
        tick();
        got[k] = txd_o;
        if (k == 0) chk("R8 break loaded before data", buf_empty_o, 1'b0);
      end
      chk("R7 break frame", got, 16'h2000);
    end
    tick();
    chk("R7 idle after break", {shift_empty_o, txd_o}, 2'b11);
    run_frame("R8 data after break", 8'h81, 1'b0, 1'b0);

    // R9: disable mid-frame, break dropped, buffer kept
    write(8'h00, 1'b0, 1'b0);
    tick(); tick(); tick();
    tx_en_i = 1'b0;
    @(negedge clk_i);
    chk("R9 abort to idle", {shift_empty_o, txd_o}, 2'b11);
    write(8'hFF, 1'b0, 1'b0);
    break_req_i = 1'b1; @(negedge clk_i); break_req_i = 1'b0;
    tick(); tick();
    chk("R9 no load while disabled", {shift_empty_o, txd_o, buf_empty_o}, 3'b110);
    tx_en_i = 1'b1;
    @(negedge clk_i);
    run_frame("R9 kept data sent, break dropped", 8'hFF, 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule